// File: doc/BRIEF.md
# Pattern-Table Bank Mapper

This block maps the 8 KB pattern space of a video address bus onto a larger pattern memory that is split into 1 KB banks. The CPU sets six bank registers and a layout-mode bit. The video side presents a 13-bit address. The block returns, combinationally, the 1 KB bank number and the 10-bit offset inside that bank. The pattern memory that uses these outputs sits outside the block.

Two of the registers each choose a 2 KB pair of banks. The pair starts on an even bank, and the second bank of the pair is the next bank up. The other four registers each choose a single 1 KB bank. The mode bit decides which 4 KB half of the pattern space holds the two pairs; the other half holds the four single banks. Every bank number is reduced modulo the configured bank count, so a register value beyond the installed memory wraps back to the start.

Top module: `chr_bank_mapper`

## Requirements
- R1: When reset is asserted (active low, asynchronous), all six registers clear to 0 and the mode bit clears to 0. The effect is immediate: slots 1 and 3 (addresses 0x0400-0x07FF and 0x0C00-0x0FFF) then read bank 1, and every other slot reads bank 0.
- R2: A write to address BASE+n, where n is 0 to 5 and BASE defaults to 0x7EF0, loads register n with the full 8-bit data. A write to any address other than BASE to BASE+6 changes no register.
- R3: For registers 0 and 1, the even bank of the pair is the register value with bit 0 cleared. The odd bank is that even value plus one.
- R4: In mode 0, the slot is video address bits [12:10]. Slots 0 and 1 use register 0's pair (even, then odd), slots 2 and 3 use register 1's pair, and slots 4, 5, 6 and 7 use registers 2, 3, 4 and 5.
- R5: In mode 1, slots 0, 1, 2 and 3 use registers 2, 3, 4 and 5. Slots 4 and 5 use register 0's pair, and slots 6 and 7 use register 1's pair.
- R6: A write to BASE+6 sets the mode to bit 1 of the written data. All other bits of that data are ignored.
- R7: The offset output equals video address bits [9:0].
- R8: The bank output is the selected bank number modulo NUM_BANKS (default 200), so it is always below NUM_BANKS.
- R9: A change of the video address shows on the outputs in the same cycle. A register or mode write takes effect at the clock edge that samples it, not before.
- R10: When the write enable is low, no register and no mode bit changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the register writes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | CPU write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| vaddr_i | input | 13 | Video pattern address |
| bank_o | output | 8 | Selected 1 KB bank, modulo NUM_BANKS |
| offset_o | output | 10 | Byte offset inside the bank |

## Verification
Address lookups have zero latency. A register write becomes visible after one clock edge. The bench drives each vector on a falling edge and samples on the next falling edge, so exactly one rising edge has latched any write it carries. A directed check samples one nanosecond after driving a write, before the rising edge, to show the old bank is still in place. Another changes only the video address with no clock edge, and a third asserts reset between edges, so both the combinational path and the asynchronous clear are checked without waiting for an edge.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_REGS = 6;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned VADDR_W  = 13;
  localparam int unsigned OFFS_W   = 10;
  localparam int unsigned MODE_BIT = 1;
  localparam logic [ADDR_W-1:0] BASE_ADDR = 16'h7EF0;

  typedef logic [NUM_REGS-1:0][REG_W-1:0] reg_bank_t;
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_map_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = BASE_ADDR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output reg_bank_t         regs_o,
  output logic              mode_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] MODE_ADDR = BASE + ADDR_W'(NUM_REGS);

  reg_bank_t         regs_q;
  logic              mode_q;
  logic [ADDR_W-1:0] rel;
  logic              hit_reg, hit_mode;

  assign rel      = wr_addr_i - BASE;
  assign hit_reg  = wr_en_i && (rel < ADDR_W'(NUM_REGS));
  assign hit_mode = wr_en_i && (wr_addr_i == MODE_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (hit_reg)  regs_q[rel[IDX_W-1:0]] <= wr_data_i;
      if (hit_mode) mode_q <= wr_data_i[MODE_BIT];
    end
  end

  assign regs_o = regs_q;
  assign mode_o = mode_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_load_chk
    p_reg_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == BASE + ADDR_W'(g)) |=> (regs_o[g] == $past(wr_data_i)));
  end

  p_mode_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == MODE_ADDR) |=> (mode_o == $past(wr_data_i[MODE_BIT])));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(regs_o) && $stable(mode_o)));
endmodule

// File: rtl/chr_slot_map.sv
module chr_slot_map
  import chr_map_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 200,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  reg_bank_t           regs_i,
  input  logic                mode_i,
  input  logic [VADDR_W-1:0]  vaddr_i,
  output logic [BANK_W-1:0]   bank_o,
  output logic [OFFS_W-1:0]   offset_o
);
  logic [2:0]       slot;
  logic             pair_half;
  logic [REG_W-1:0] sel_reg;
  logic [REG_W-1:0] raw_bank;

  assign slot      = vaddr_i[VADDR_W-1:OFFS_W];
  assign pair_half = (slot[2] == mode_i);

  always_comb begin
    if (pair_half) begin
      // pair: even bank from reg 0/1, odd bank = even + 1
      sel_reg  = regs_i[slot[1]];
      raw_bank = {sel_reg[REG_W-1:1], slot[0]};
    end else begin
      sel_reg  = regs_i[3'd2 + {1'b0, slot[1:0]}];
      raw_bank = sel_reg;
    end
  end

  if (NUM_BANKS == (1 << BANK_W)) begin : g_pow2
    if (BANK_W < REG_W) begin : g_trunc
      assign bank_o = raw_bank[BANK_W-1:0];
    end else begin : g_ext
      assign bank_o = BANK_W'(raw_bank);
    end
  end else begin : g_mod
    localparam int unsigned MW = (BANK_W > REG_W) ? BANK_W : REG_W;
    localparam logic [MW-1:0] NB = MW'(NUM_BANKS);
    logic [MW-1:0] wrapped;
    assign wrapped = MW'(raw_bank) % NB;
    assign bank_o  = wrapped[BANK_W-1:0];
  end

  assign offset_o = vaddr_i[OFFS_W-1:0];
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 200,
  parameter logic [15:0] BASE      = BASE_ADDR,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [12:0]       vaddr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [9:0]        offset_o
);
  reg_bank_t regs;
  logic      mode;

  chr_bank_regs #(.BASE(BASE)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs),
    .mode_o    (mode)
  );

  chr_slot_map #(.NUM_BANKS(NUM_BANKS)) u_map (
    .regs_i   (regs),
    .mode_i   (mode),
    .vaddr_i  (vaddr_i),
    .bank_o   (bank_o),
    .offset_o (offset_o)
  );

  p_bank_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(bank_o) < int'(NUM_BANKS));
endmodule

// File: tb/chr_bank_mapper_bench.sv
module chr_bank_mapper_bench;
  localparam int unsigned NB = 200;
  localparam int unsigned BW = $clog2(NB);

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [12:0] vaddr;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h7EF0, 8'h05, 13'h0000, 8'd4},   // R3 R4 even, lsb cleared
    '{1'b0, 16'h0000, 8'h00, 13'h0523, 8'd5},   // R3 odd
    '{1'b1, 16'h7EF1, 8'h06, 13'h0800, 8'd6},   // R4
    '{1'b0, 16'h0000, 8'h00, 13'h0DEF, 8'd7},   // R4 R7
    '{1'b1, 16'h7EF2, 8'h02, 13'h1000, 8'd2},   // R4
    '{1'b1, 16'h7EF3, 8'h03, 13'h1401, 8'd3},
    '{1'b1, 16'h7EF4, 8'h04, 13'h1800, 8'd4},
    '{1'b1, 16'h7EF5, 8'h0B, 13'h1C00, 8'd11},
    '{1'b1, 16'h7EF6, 8'h02, 13'h0000, 8'd2},   // R6 R5 mode 1
    '{1'b0, 16'h0000, 8'h00, 13'h0400, 8'd3},
    '{1'b0, 16'h0000, 8'h00, 13'h0A55, 8'd4},
    '{1'b0, 16'h0000, 8'h00, 13'h0C00, 8'd11},
    '{1'b0, 16'h0000, 8'h00, 13'h1000, 8'd4},
    '{1'b0, 16'h0000, 8'h00, 13'h1400, 8'd5},
    '{1'b0, 16'h0000, 8'h00, 13'h1800, 8'd6},
    '{1'b0, 16'h0000, 8'h00, 13'h1FFF, 8'd7},
    '{1'b1, 16'h7EF6, 8'hFD, 13'h0000, 8'd4},   // R6 other bits ignored
    '{1'b1, 16'h7EF7, 8'h55, 13'h1C00, 8'd11},  // R2 out of range
    '{1'b1, 16'h7EEF, 8'h66, 13'h0000, 8'd4},   // R2 below base
    '{1'b0, 16'h7EF5, 8'h99, 13'h1C00, 8'd11},  // R10
    '{1'b1, 16'h7EF0, 8'hFF, 13'h0000, 8'd54},  // R8 254 mod 200
    '{1'b0, 16'h0000, 8'h00, 13'h0400, 8'd55},
    '{1'b1, 16'h7EF5, 8'hC8, 13'h1C00, 8'd0},   // R8 200 -> 0
    '{1'b1, 16'h7EF1, 8'hC9, 13'h0800, 8'd0},   // R8 pair 200
    '{1'b0, 16'h0000, 8'h00, 13'h0FFF, 8'd1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [15:0]   wr_addr_i = '0;
  logic [7:0]    wr_data_i = '0;
  logic [12:0]   vaddr_i = '0;
  logic [BW-1:0] bank_o;
  logic [9:0]    offset_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  chr_bank_mapper #(.NUM_BANKS(NB)) u_chr_bank_mapper (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .vaddr_i, .bank_o, .offset_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    vaddr_i = 13'h0400;
    #1 check("R1 slot1 in reset", int'(bank_o), 1);
    vaddr_i = 13'h1000;
    #1 check("R1 slot4 in reset", int'(bank_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      wr_en_i   = VECS[i].wr;
      wr_addr_i = VECS[i].addr;
      wr_data_i = VECS[i].data;
      vaddr_i   = VECS[i].vaddr;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      check($sformatf("R2-table bank vec %0d", i), int'(bank_o), int'(VECS[i].exp));
      check($sformatf("R7 offset vec %0d", i), int'(offset_o), int'(VECS[i].vaddr[9:0]));
    end

    // R9 write not visible before the edge, visible after
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 16'h7EF2; wr_data_i = 8'h30; vaddr_i = 13'h1000;
    #1 check("R9 before edge", int'(bank_o), 2);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R9 after edge", int'(bank_o), 48);
    // R9 address change without a clock edge
    vaddr_i = 13'h1400;
    #1 check("R9 combinational lookup", int'(bank_o), 3);
    check("R7 offset zero", int'(offset_o), 0);

    // R1 async reset mid-run, mode back to 0
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 16'h7EF6; wr_data_i = 8'h02;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    vaddr_i = 13'h0400;
    #1 check("R5 mode1 slot1 reg3", int'(bank_o), 3);
    rst_ni = 1'b0;
    #1 check("R1 slot1 after reset", int'(bank_o), 1);
    vaddr_i = 13'h1C00;
    #1 check("R1 slot7 after reset", int'(bank_o), 0);
    vaddr_i = 13'h0800;
    #1 check("R1 slot2 after reset", int'(bank_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 disabled write at pair register has no effect
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_addr_i = 16'h7EF0; wr_data_i = 8'h40; vaddr_i = 13'h0000;
    @(negedge clk_i);
    check("R10 disabled write", int'(bank_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule